// File: doc/BRIEF.md
# Weighted Vote Tally Encoder

This block turns three yes/no ballots of unequal weight into a 4-bit code for a BCD seven-segment decoder stage. The chair's yes is worth five votes, the senior's yes three and the member's yes two. The code carries the weighted yes total. Two cases are special. When nobody votes yes, the block sends the code the decoder treats as "blank" (15), so the display goes dark. When everybody votes yes, the total of ten wraps to the single digit 0.

In its default build the block holds a snapshot register. While the latch enable is high, the ballots are sampled on each rising clock edge and the code reflects that sample. While the latch enable is low, the displayed result stays frozen however the switches move. A synchronous reset loads the blank code. A build parameter can remove the register, and the code then follows the ballots directly. The weights, the code width and the two special codes are all parameters.

Top module: `weighted_vote_tally`

## Requirements
- R1: With only the member voting yes (ballot bits chair,senior,member = 001), the code is 2.
- R2: With only the senior voting yes (010), the code is 3.
- R3: With only the chair voting yes (100), the code is 5.
- R4: With no yes ballot (000), the code is 15, the value the downstream decoder blanks on.
- R5: With all three voting yes (111), the code is 0.
- R6: Any other mix shows the weighted sum: 011 gives 5, 101 gives 7, 110 gives 8.
- R7: While latch_en is high and rst is low, the ballots present at a rising clock edge set the code, and the new code is visible right after that edge.
- R8: While latch_en is low, the code does not change at the next edge, whatever the ballot inputs do.
- R9: rst is synchronous and active high. It sets the code to 15 at the next edge and wins over latch_en.
- R10: The code only ever takes one of the values 0, 2, 3, 5, 7, 8 or 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the snapshot register |
| rst | input | 1 | Synchronous reset, active high; loads the blank code |
| latch_en | input | 1 | High: sample the ballots at each rising edge; low: hold |
| chair_yes | input | 1 | Chair ballot, 1 = yes (weight 5) |
| senior_yes | input | 1 | Senior ballot, 1 = yes (weight 3) |
| member_yes | input | 1 | Member ballot, 1 = yes (weight 2) |
| tally_code | output | 4 | Code for the BCD seven-segment decoder |

## Verification
The hardest case to observe is the frozen snapshot. With latch_en low, the ballots can swing to values that would produce a very different code, including the two special codes. The output has to show none of that. To reach this case, the stimulus first latches a plain total, then drops latch_en and walks the ballots through all-yes and all-no, sampling between changes. Finally it raises latch_en again to confirm the block is still live. Reset is also driven together with a high latch_en and an all-yes ballot, so that the reset priority is visible at the code itself.

// File: rtl/vote_tally_pkg.sv
package vote_tally_pkg;

   // Ballot order inside the packed vote vector; the code map depends on it
   typedef enum int {
      IDX_MEMBER = 0,
      IDX_SENIOR = 1,
      IDX_CHAIR  = 2
   } voter_idx_e;

   localparam int NUM_VOTERS = 3;

   // Compile-time helper: bits needed for a value
   function automatic int bits_for(input int value);
      int b;
      b = 1;
      while ((1 << b) <= value) b++;
      return b;
   endfunction

endpackage

// File: rtl/vote_weight_sum.sv
module vote_weight_sum #(
   parameter int                         NUM_IN     = 3,
   parameter int                         SUM_W      = 4,
   parameter logic [NUM_IN*SUM_W-1:0]    WEIGHT_VEC = '0
) (
   input  logic [NUM_IN-1:0] yes_vec,
   output logic [SUM_W-1:0]  weighted_sum
);

   logic [SUM_W-1:0] partial [NUM_IN+1];

   assign partial[0] = '0;

   // One adder stage per voter: add the weight only on a yes ballot
   for (genvar i = 0; i < NUM_IN; i++) begin : g_stage
      localparam logic [SUM_W-1:0] STAGE_WEIGHT = WEIGHT_VEC[i*SUM_W +: SUM_W];
      assign partial[i+1] = partial[i] + (yes_vec[i] ? STAGE_WEIGHT : '0);
   end

   assign weighted_sum = partial[NUM_IN];

endmodule

// File: rtl/vote_code_map.sv
module vote_code_map #(
   parameter int               NUM_IN       = 3,
   parameter int               CODE_W       = 4,
   parameter logic [CODE_W-1:0] NONE_CODE   = '1,
   parameter logic [CODE_W-1:0] ALL_CODE    = '0
) (
   input  logic [NUM_IN-1:0] yes_vec,
   input  logic [CODE_W-1:0] weighted_sum,
   output logic [CODE_W-1:0] code
);

   logic nobody_yes;
   logic everybody_yes;

   assign nobody_yes    = ~|yes_vec;
   assign everybody_yes = &yes_vec;

   always_comb begin
      if (nobody_yes)         code = NONE_CODE;
      else if (everybody_yes) code = ALL_CODE;
      else                    code = weighted_sum;
   end

endmodule

// File: rtl/vote_snapshot_reg.sv
module vote_snapshot_reg #(
   parameter bit                REGISTERED = 1'b1,
   parameter int                DATA_W     = 4,
   parameter logic [DATA_W-1:0] RESET_VAL  = '1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   if (REGISTERED) begin : g_reg
      logic [DATA_W-1:0] held;
      always_ff @(posedge clk) begin
         if (rst)       held <= RESET_VAL;
         else if (load) held <= d;
      end
      assign q = held;
   end else begin : g_pass
      assign q = d;
   end

endmodule

// File: rtl/weighted_vote_tally.sv
module weighted_vote_tally #(
   parameter int CODE_W        = 4,
   parameter int CHAIR_WEIGHT  = 5,
   parameter int SENIOR_WEIGHT = 3,
   parameter int MEMBER_WEIGHT = 2,
   parameter int BLANK_CODE    = 15,
   parameter int ALL_YES_CODE  = 0,
   parameter bit SNAPSHOT      = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              latch_en,
   input  logic              chair_yes,
   input  logic              senior_yes,
   input  logic              member_yes,
   output logic [CODE_W-1:0] tally_code
);

   import vote_tally_pkg::*;

   localparam int TOTAL_WEIGHT = CHAIR_WEIGHT + SENIOR_WEIGHT + MEMBER_WEIGHT;
   localparam int TOTAL_BITS   = bits_for(TOTAL_WEIGHT);
   localparam logic [NUM_VOTERS*CODE_W-1:0] WEIGHTS =
      {CODE_W'(CHAIR_WEIGHT), CODE_W'(SENIOR_WEIGHT), CODE_W'(MEMBER_WEIGHT)};
   localparam logic [CODE_W-1:0] NONE_C = CODE_W'(BLANK_CODE);
   localparam logic [CODE_W-1:0] ALL_C  = CODE_W'(ALL_YES_CODE);

   // Elaboration-time parameter checks
   if (TOTAL_BITS > CODE_W) begin : g_bad_width
      $error("weighted_vote_tally: total weight does not fit CODE_W");
   end
   if (CHAIR_WEIGHT < 1 || SENIOR_WEIGHT < 1 || MEMBER_WEIGHT < 1) begin : g_bad_weight
      $error("weighted_vote_tally: every weight must be positive");
   end
   if (BLANK_CODE >= (1 << CODE_W) || ALL_YES_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("weighted_vote_tally: special code out of range");
   end

   logic [NUM_VOTERS-1:0] yes_vec;
   logic [CODE_W-1:0]     sum_w;
   logic [CODE_W-1:0]     code_next;

   assign yes_vec[IDX_CHAIR]  = chair_yes;
   assign yes_vec[IDX_SENIOR] = senior_yes;
   assign yes_vec[IDX_MEMBER] = member_yes;

   vote_weight_sum #(
      .NUM_IN     (NUM_VOTERS),
      .SUM_W      (CODE_W),
      .WEIGHT_VEC (WEIGHTS)
   ) sum_i (
      .yes_vec      (yes_vec),
      .weighted_sum (sum_w)
   );

   vote_code_map #(
      .NUM_IN    (NUM_VOTERS),
      .CODE_W    (CODE_W),
      .NONE_CODE (NONE_C),
      .ALL_CODE  (ALL_C)
   ) map_i (
      .yes_vec      (yes_vec),
      .weighted_sum (sum_w),
      .code         (code_next)
   );

   vote_snapshot_reg #(
      .REGISTERED (SNAPSHOT),
      .DATA_W     (CODE_W),
      .RESET_VAL  (NONE_C)
   ) snap_i (
      .clk  (clk),
      .rst  (rst),
      .load (latch_en),
      .d    (code_next),
      .q    (tally_code)
   );

endmodule

// File: rtl/vote_tally_chk.sv
module vote_tally_chk #(
   parameter int CODE_W   = 4,
   parameter bit SNAPSHOT = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              latch_en,
   input logic              chair_yes,
   input logic              senior_yes,
   input logic              member_yes,
   input logic [CODE_W-1:0] tally_code
);

   // Expected code for the default 5/3/2 weighting, indexed {chair,senior,member}
   function automatic logic [CODE_W-1:0] table_code(input logic [2:0] v);
      case (v)
         3'b000:  return CODE_W'(15);
         3'b001:  return CODE_W'(2);
         3'b010:  return CODE_W'(3);
         3'b011:  return CODE_W'(5);
         3'b100:  return CODE_W'(5);
         3'b101:  return CODE_W'(7);
         3'b110:  return CODE_W'(8);
         default: return CODE_W'(0);
      endcase
   endfunction

   logic [2:0] ballots;
   assign ballots = {chair_yes, senior_yes, member_yes};

   if (SNAPSHOT) begin : g_seq
      // R7
      latch_follows_chk: assert property (@(posedge clk) disable iff (rst)
         latch_en |=> tally_code == table_code($past(ballots)));

      // R8
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
         !latch_en |=> $stable(tally_code));

      // R9
      reset_blank_chk: assert property (@(posedge clk)
         rst |=> tally_code == CODE_W'(15));

      // R4
      none_blank_chk: assert property (@(posedge clk) disable iff (rst)
         (latch_en && ballots == 3'b000) |=> tally_code == CODE_W'(15));

      // R5
      all_wraps_chk: assert property (@(posedge clk) disable iff (rst)
         (latch_en && ballots == 3'b111) |=> tally_code == CODE_W'(0));

      // R10
      always @(posedge clk) begin
         if (!rst) begin
            legal_code_chk: assert (tally_code == 0 || tally_code == 2 ||
                                    tally_code == 3 || tally_code == 5 ||
                                    tally_code == 7 || tally_code == 8 ||
                                    tally_code == 15);
         end
      end
   end else begin : g_comb
      // R6
      always @(posedge clk) begin
         comb_map_chk: assert (tally_code == table_code(ballots));
      end
   end

endmodule

bind weighted_vote_tally vote_tally_chk #(
   .CODE_W   (CODE_W),
   .SNAPSHOT (SNAPSHOT)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .latch_en   (latch_en),
   .chair_yes  (chair_yes),
   .senior_yes (senior_yes),
   .member_yes (member_yes),
   .tally_code (tally_code)
);

// File: tb/weighted_vote_tally_tb_top.sv
module weighted_vote_tally_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       latch_en;
   logic       chair_yes, senior_yes, member_yes;
   logic [3:0] tally_code;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   weighted_vote_tally dut_i (
      .clk        (clk),
      .rst        (rst),
      .latch_en   (latch_en),
      .chair_yes  (chair_yes),
      .senior_yes (senior_yes),
      .member_yes (member_yes),
      .tally_code (tally_code)
   );

   // {chair,senior,member, expected code}
   localparam logic [6:0] VECTORS [8] = '{
      {3'b000, 4'd15}, {3'b001, 4'd2}, {3'b010, 4'd3}, {3'b011, 4'd5},
      {3'b100, 4'd5},  {3'b101, 4'd7}, {3'b110, 4'd8}, {3'b111, 4'd0}
   };

   function automatic string tag_for(input logic [2:0] v);
      case (v)
         3'b000:  return "R4";
         3'b001:  return "R1";
         3'b010:  return "R2";
         3'b100:  return "R3";
         3'b111:  return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [3:0] expected);
      n_checks++;
      if (tally_code !== expected) begin
         n_fails++;
         $display("FAIL %s: tally_code=%0d expected=%0d", req, tally_code, expected);
      end
   endtask

   task automatic check_legal();
      n_checks++;
      if (!(tally_code inside {4'd0, 4'd2, 4'd3, 4'd5, 4'd7, 4'd8, 4'd15})) begin
         n_fails++;
         $display("FAIL R10: tally_code=%0d expected one of 0,2,3,5,7,8,15", tally_code);
      end
   endtask

   // Drive at a falling edge; the next rising edge acts; return at the following falling edge
   task automatic apply(input logic r, input logic le, input logic [2:0] v);
      @(negedge clk);
      rst = r;
      latch_en = le;
      {chair_yes, senior_yes, member_yes} = v;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      rst = 1'b1;
      latch_en = 1'b0;
      {chair_yes, senior_yes, member_yes} = 3'b000;
      repeat (2) @(negedge clk);
      check("R9", 4'd15);  // reset state

      // Table walk with latch enabled
      for (int i = 0; i < 8; i++) begin
         apply(1'b0, 1'b1, VECTORS[i][6:4]);
         check(tag_for(VECTORS[i][6:4]), VECTORS[i][3:0]);
         check_legal();
      end

      // R7: back-to-back changes, each visible right after its edge
      apply(1'b0, 1'b1, 3'b101);
      check("R7", 4'd7);
      apply(1'b0, 1'b1, 3'b010);
      check("R7", 4'd3);

      // R8: frozen snapshot while ballots move to special cases
      apply(1'b0, 1'b1, 3'b001);
      check("R1", 4'd2);
      apply(1'b0, 1'b0, 3'b111);
      check("R8", 4'd2);
      apply(1'b0, 1'b0, 3'b000);
      check("R8", 4'd2);
      apply(1'b0, 1'b0, 3'b110);
      check("R8", 4'd2);
      apply(1'b0, 1'b1, 3'b110);
      check("R7", 4'd8);

      // R9: reset wins over latch_en with an all-yes ballot
      apply(1'b1, 1'b1, 3'b111);
      check("R9", 4'd15);
      apply(1'b0, 1'b0, 3'b111);
      check("R9", 4'd15);  // still blank, latch off after reset
      apply(1'b0, 1'b1, 3'b111);
      check("R5", 4'd0);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

endmodule